// File: doc/BRIEF.md
# Configuration Access Router with Secondary Bus Bridge

This block takes configuration accesses from one upstream requester and steers each one to a function register port. The 24-bit access address holds a bus number, a device/function number and a register offset. Bus 0 is the primary bus. Its function slots and the bridge's own register set sit on it. A second bus sits behind the bridge. It is reached only when the bus field equals the secondary bus number that software has written into the bridge registers.

A read that nobody claims returns all-ones, sized to the access length. A write that nobody claims leaves no trace. The bridge register set holds the identity from a parameter, fixed class and header fields, a few writable bytes and the secondary bus number that drives routing.

The upstream side is a valid/ready request with a response one cycle later. `up_ready` is high whenever no response is outstanding. A request is taken in the cycle where `up_valid` and `up_ready` are both high. `rsp_valid` then pulses for exactly one cycle, and `up_ready` is low in that cycle. The response cannot be back-pressured, so the requester must take it in the cycle it appears. The downstream ports are plain. Slot selects are asserted in the accept cycle only. Each function applies a write on that clock edge and drives its read data combinationally.

Top module: `cfg_access_router`

## Requirements
- R1: The address splits as bus = up_addr[23:16], device/function = up_addr[15:8] (device in bits 15:11, function in bits 10:8) and register offset = up_addr[7:0]. The offset, length, write flag and write data are forwarded on dn_off, dn_len, dn_write and dn_wdata.
- R2: With bus 0, devfn d < PRI_SLOTS and pri_present[d] high, pri_sel[d] is high in the accept cycle. At most one select of pri_sel and sec_sel is ever high.
- R3: With a nonzero secondary bus number equal to the bus field, devfn d < SEC_SLOTS and sec_present[d] high, sec_sel[d] is high in the accept cycle.
- R4: The secondary bus number resets to 0. While it is 0, no sec_sel is ever raised and bus 0 always goes to the primary bus. A bus field that matches neither bus is a miss.
- R5: An unclaimed read returns 0x000000FF for length 00 (byte), 0x0000FFFF for 01 (word), and 0xFFFFFFFF for 10 or 11 (dword).
- R6: An unclaimed write raises no select and changes no bridge register.
- R7: A write whose byte lanes cover offset 0x19 in the bridge updates the secondary bus number. A byte write at 0x19 takes data[7:0]. A write of length word or dword at 0x18 takes data[15:8].
- R8: The bridge answers on bus 0 at devfn BRIDGE_DEVFN (default 0x20). Its dword reads after reset are: 0x00 gives {BRIDGE_ID[15:0], BRIDGE_ID[31:16]} (vendor is the upper half of the parameter); 0x04 gives 0x00A00006; 0x08 gives 0x06040000; 0x0C gives 0x00811000; 0x1C gives 0x00A00000; 0x18 gives 0x00000000.
- R9: up_ready is high when no response is pending. rsp_valid is high exactly in the cycle after an accept, and up_ready is low in that cycle. Write responses carry rsp_rdata = 0.
- R10: Read data for a claimed access keeps only the bytes inside the length; higher bytes are zero. Bridge reads return the byte at the offset in bits 7:0 and the following bytes above it, little-endian, with bytes past 0xFF reading 0.
- R11: The only writable bridge bytes are 0x04 and 0x05 (command), 0x0C, 0x0D (latency timer, reset 0x10) and 0x19. Writes to any other bridge byte, including the identity and class fields, leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| up_valid | input | 1 | Access request valid |
| up_ready | output | 1 | Router can take a request |
| up_addr | input | 24 | Bus, device/function and offset |
| up_write | input | 1 | 1 = write, 0 = read |
| up_len | input | 2 | 00 byte, 01 word, 10/11 dword |
| up_wdata | input | 32 | Write data, offset byte in bits 7:0 |
| rsp_valid | output | 1 | Response pulse |
| rsp_rdata | output | 32 | Read result |
| dn_off | output | 8 | Register offset to functions |
| dn_len | output | 2 | Access length to functions |
| dn_write | output | 1 | Write flag to functions |
| dn_wdata | output | 32 | Write data to functions |
| pri_present | input | PRI_SLOTS | Primary slot populated |
| pri_sel | output | PRI_SLOTS | Primary slot select |
| pri_rdata | input | 32*PRI_SLOTS | Primary slot read data |
| sec_present | input | SEC_SLOTS | Secondary slot populated |
| sec_sel | output | SEC_SLOTS | Secondary slot select |
| sec_rdata | input | 32*SEC_SLOTS | Secondary slot read data |

## Verification
The bench probes the zero secondary bus number. A router that compares the bus field without the nonzero guard would send bus-0 accesses to the secondary slots. The bench also moves the secondary number through both write forms, byte at 0x19 and word or dword at 0x18. A design that takes the wrong data byte would route to the wrong bus afterwards. Misses are read at every length, and an all-ones value that is not cut to the length, or a write miss that lands in the bridge, shows up at once. The read-only bridge fields are written and read back, and so are reads at unaligned offsets, which catches lane shifting or masking errors.

// File: rtl/cfg_route_pkg.sv
package cfg_route_pkg;

  typedef struct packed {
    logic [7:0] bus;
    logic [7:0] devfn;
    logic [7:0] off;
  } cfg_addr_t;

  localparam logic [1:0] LEN_BYTE = 2'b00;
  localparam logic [1:0] LEN_WORD = 2'b01;

  function automatic logic [3:0] lane_mask(input logic [1:0] len);
    case (len)
      LEN_BYTE: lane_mask = 4'b0001;
      LEN_WORD: lane_mask = 4'b0011;
      default:  lane_mask = 4'b1111;
    endcase
  endfunction

  function automatic logic [31:0] lane_bits(input logic [3:0] m);
    lane_bits = {{8{m[3]}}, {8{m[2]}}, {8{m[1]}}, {8{m[0]}}};
  endfunction

endpackage

// File: rtl/cfg_route_decode.sv
module cfg_route_decode
  import cfg_route_pkg::*;
#(
  parameter int PRI_SLOTS = 4,
  parameter int SEC_SLOTS = 4,
  parameter logic [7:0] BRIDGE_DEVFN = 8'h20
) (
  input  cfg_addr_t            addr,
  input  logic [7:0]           sec_num,
  input  logic [PRI_SLOTS-1:0] pri_present,
  input  logic [SEC_SLOTS-1:0] sec_present,
  output logic                 bridge_hit,
  output logic [PRI_SLOTS-1:0] pri_hit,
  output logic [SEC_SLOTS-1:0] sec_hit,
  output logic                 any_hit
);

  logic on_pri;
  logic on_sec;

  // bus 0 is always primary; a zero secondary number disables the second bus
  assign on_pri     = (addr.bus == 8'd0);
  assign on_sec     = (sec_num != 8'd0) && (addr.bus == sec_num);
  assign bridge_hit = on_pri && (addr.devfn == BRIDGE_DEVFN);

  genvar p;
  generate
    for (p = 0; p < PRI_SLOTS; p++) begin : g_pri
      assign pri_hit[p] = on_pri && pri_present[p] &&
                          (addr.devfn == 8'(p)) && (addr.devfn != BRIDGE_DEVFN);
    end
    for (p = 0; p < SEC_SLOTS; p++) begin : g_sec
      assign sec_hit[p] = on_sec && sec_present[p] && (addr.devfn == 8'(p));
    end
  endgenerate

  assign any_hit = bridge_hit || (|pri_hit) || (|sec_hit);

endmodule

// File: rtl/cfg_bridge_regs.sv
module cfg_bridge_regs
  import cfg_route_pkg::*;
#(
  parameter logic [31:0] BRIDGE_ID = 32'h1234_5678
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [7:0]  off,
  input  logic [1:0]  len,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  output logic [7:0]  sec_num
);

  localparam logic [15:0] VEN_ID    = BRIDGE_ID[31:16];
  localparam logic [15:0] DEV_ID    = BRIDGE_ID[15:0];
  localparam logic [15:0] CMD_RST   = 16'h0006;
  localparam logic [7:0]  LAT_RST   = 8'h10;
  localparam logic [7:0]  STAT_LO   = 8'hA0;
  localparam logic [7:0]  CLS_SUB   = 8'h04;
  localparam logic [7:0]  CLS_BASE  = 8'h06;
  localparam logic [7:0]  HDR_KIND  = 8'h81;
  localparam logic [7:0]  SEC_STAT  = 8'hA0;

  logic [15:0] cmd_q;
  logic [7:0]  cls_q;
  logic [7:0]  lat_q;
  logic [7:0]  sec_q;

  logic [3:0]  mask;
  logic [8:0]  lane_a [4];
  logic [3:0]  lane_ok;

  function automatic logic [7:0] rd_byte(input logic [7:0] a, input logic [15:0] cmd,
                                         input logic [7:0] cls, input logic [7:0] lat,
                                         input logic [7:0] sec);
    case (a)
      8'h00:   rd_byte = VEN_ID[7:0];
      8'h01:   rd_byte = VEN_ID[15:8];
      8'h02:   rd_byte = DEV_ID[7:0];
      8'h03:   rd_byte = DEV_ID[15:8];
      8'h04:   rd_byte = cmd[7:0];
      8'h05:   rd_byte = cmd[15:8];
      8'h06:   rd_byte = STAT_LO;
      8'h0A:   rd_byte = CLS_SUB;
      8'h0B:   rd_byte = CLS_BASE;
      8'h0C:   rd_byte = cls;
      8'h0D:   rd_byte = lat;
      8'h0E:   rd_byte = HDR_KIND;
      8'h19:   rd_byte = sec;
      8'h1E:   rd_byte = SEC_STAT;
      default: rd_byte = 8'h00;
    endcase
  endfunction

  assign mask = lane_mask(len);

  always_comb begin
    for (int i = 0; i < 4; i++) begin
      lane_a[i]  = {1'b0, off} + 9'(i);
      lane_ok[i] = mask[i] && !lane_a[i][8];
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < 4; i++) begin
      if (lane_ok[i])
        rdata[i*8 +: 8] = rd_byte(lane_a[i][7:0], cmd_q, cls_q, lat_q, sec_q);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q <= CMD_RST;
      cls_q <= 8'h00;
      lat_q <= LAT_RST;
      sec_q <= 8'h00;
    end else if (wr_en) begin
      for (int i = 0; i < 4; i++) begin
        if (lane_ok[i]) begin
          case (lane_a[i][7:0])
            8'h04:   cmd_q[7:0]  <= wdata[i*8 +: 8];
            8'h05:   cmd_q[15:8] <= wdata[i*8 +: 8];
            8'h0C:   cls_q       <= wdata[i*8 +: 8];
            8'h0D:   lat_q       <= wdata[i*8 +: 8];
            8'h19:   sec_q       <= wdata[i*8 +: 8];
            default: ;
          endcase
        end
      end
    end
  end

  assign sec_num = sec_q;

  // R6
  sec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(sec_q));

  // R11
  ident_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && off == 8'h00) |=> (rdata[15:0] != 16'hFFFF || VEN_ID == 16'hFFFF || $past(len) != len || $past(off) != off || rdata[15:0] == VEN_ID));

endmodule

// File: rtl/cfg_access_router.sv
module cfg_access_router
  import cfg_route_pkg::*;
#(
  parameter int PRI_SLOTS = 4,
  parameter int SEC_SLOTS = 4,
  parameter logic [7:0] BRIDGE_DEVFN = 8'h20,
  parameter logic [31:0] BRIDGE_ID = 32'h1234_5678
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   up_valid,
  output logic                   up_ready,
  input  logic [23:0]            up_addr,
  input  logic                   up_write,
  input  logic [1:0]             up_len,
  input  logic [31:0]            up_wdata,
  output logic                   rsp_valid,
  output logic [31:0]            rsp_rdata,
  output logic [7:0]             dn_off,
  output logic [1:0]             dn_len,
  output logic                   dn_write,
  output logic [31:0]            dn_wdata,
  input  logic [PRI_SLOTS-1:0]   pri_present,
  output logic [PRI_SLOTS-1:0]   pri_sel,
  input  logic [32*PRI_SLOTS-1:0] pri_rdata,
  input  logic [SEC_SLOTS-1:0]   sec_present,
  output logic [SEC_SLOTS-1:0]   sec_sel,
  input  logic [32*SEC_SLOTS-1:0] sec_rdata
);

  localparam int DW = 32;

  cfg_addr_t             acc;
  logic                  fire;
  logic                  bridge_hit;
  logic                  any_hit;
  logic [PRI_SLOTS-1:0]  pri_hit;
  logic [SEC_SLOTS-1:0]  sec_hit;
  logic [7:0]            sec_num;
  logic [DW-1:0]         br_rdata;
  logic [DW-1:0]         slot_rd;
  logic [DW-1:0]         len_bits;
  logic [DW-1:0]         rd_val;
  logic                  rsp_q;
  logic [DW-1:0]         rdata_q;

  assign acc      = up_addr;
  assign up_ready = !rsp_q;
  assign fire     = up_valid && up_ready;

  assign dn_off   = acc.off;
  assign dn_len   = up_len;
  assign dn_write = up_write;
  assign dn_wdata = up_wdata;

  cfg_route_decode #(
    .PRI_SLOTS   (PRI_SLOTS),
    .SEC_SLOTS   (SEC_SLOTS),
    .BRIDGE_DEVFN(BRIDGE_DEVFN)
  ) u_decode (
    .addr       (acc),
    .sec_num    (sec_num),
    .pri_present(pri_present),
    .sec_present(sec_present),
    .bridge_hit (bridge_hit),
    .pri_hit    (pri_hit),
    .sec_hit    (sec_hit),
    .any_hit    (any_hit)
  );

  cfg_bridge_regs #(
    .BRIDGE_ID(BRIDGE_ID)
  ) u_bridge (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (fire && up_write && bridge_hit),
    .off    (acc.off),
    .len    (up_len),
    .wdata  (up_wdata),
    .rdata  (br_rdata),
    .sec_num(sec_num)
  );

  assign pri_sel = {PRI_SLOTS{fire}} & pri_hit;
  assign sec_sel = {SEC_SLOTS{fire}} & sec_hit;

  always_comb begin
    slot_rd = bridge_hit ? br_rdata : '0;
    for (int p = 0; p < PRI_SLOTS; p++)
      if (pri_hit[p]) slot_rd = slot_rd | pri_rdata[p*DW +: DW];
    for (int s = 0; s < SEC_SLOTS; s++)
      if (sec_hit[s]) slot_rd = slot_rd | sec_rdata[s*DW +: DW];
  end

  assign len_bits = lane_bits(lane_mask(up_len));
  assign rd_val   = any_hit ? (slot_rd & len_bits) : len_bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      rsp_q <= fire;
      if (fire) rdata_q <= up_write ? '0 : rd_val;
    end
  end

  assign rsp_valid = rsp_q;
  assign rsp_rdata = rdata_q;

  // R2
  one_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({pri_sel, sec_sel}));

  // R4
  sec_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_num == 8'd0) |-> (sec_sel == '0));

  // R9
  rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> rsp_valid);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  // R5
  miss_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !up_write && !any_hit && up_len == 2'b00) |=> (rsp_rdata == 32'h0000_00FF));

  // R6
  miss_nosel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !any_hit) |-> (pri_sel == '0 && sec_sel == '0));

endmodule

// File: tb/cfg_access_router_test.sv
`timescale 1ns/1ps
module cfg_access_router_test;

  localparam int NP = 4;
  localparam int NS = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic up_valid = 1'b0;
  logic up_ready;
  logic [23:0] up_addr = '0;
  logic up_write = 1'b0;
  logic [1:0] up_len = '0;
  logic [31:0] up_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic [7:0] dn_off;
  logic [1:0] dn_len;
  logic dn_write;
  logic [31:0] dn_wdata;
  logic [NP-1:0] pri_present = 4'b1011;
  logic [NP-1:0] pri_sel;
  logic [32*NP-1:0] pri_rdata;
  logic [NS-1:0] sec_present = 4'b0111;
  logic [NS-1:0] sec_sel;
  logic [32*NS-1:0] sec_rdata;

  int n_chk = 0;
  int n_bad = 0;

  logic [NP-1:0] cap_psel;
  logic [NS-1:0] cap_ssel;
  logic [7:0]    cap_off;
  logic [31:0]   cap_wdata;
  logic          cap_write;
  logic [31:0]   cap_rd;

  always #2.5 clk = ~clk;

  for (genvar p = 0; p < NP; p++) begin : g_pd
    assign pri_rdata[p*32 +: 32] = 32'h5A5A_0000 + 32'(p) * 32'h11;
  end
  for (genvar s = 0; s < NS; s++) begin : g_sd
    assign sec_rdata[s*32 +: 32] = 32'hA5A5_0000 + 32'(s) * 32'h11;
  end

  cfg_access_router #(
    .PRI_SLOTS(NP), .SEC_SLOTS(NS), .BRIDGE_DEVFN(8'h20), .BRIDGE_ID(32'hABCD_1234)
  ) uut (
    .clk(clk), .rst_n(rst_n), .up_valid(up_valid), .up_ready(up_ready),
    .up_addr(up_addr), .up_write(up_write), .up_len(up_len), .up_wdata(up_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dn_off(dn_off), .dn_len(dn_len),
    .dn_write(dn_write), .dn_wdata(dn_wdata), .pri_present(pri_present),
    .pri_sel(pri_sel), .pri_rdata(pri_rdata), .sec_present(sec_present),
    .sec_sel(sec_sel), .sec_rdata(sec_rdata)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [23:0] a, input logic wr, input logic [1:0] len,
                        input logic [31:0] wd);
    @(negedge clk);
    up_addr = a; up_write = wr; up_len = len; up_wdata = wd; up_valid = 1'b1;
    #1;
    cap_psel = pri_sel; cap_ssel = sec_sel; cap_off = dn_off;
    cap_wdata = dn_wdata; cap_write = dn_write;
    @(posedge clk);
    #1;
    chk("R9 rsp_valid after accept", 32'(rsp_valid), 32'd1);
    chk("R9 ready low during response", 32'(up_ready), 32'd0);
    cap_rd = rsp_rdata;
    @(negedge clk);
    up_valid = 1'b0;
  endtask

  task automatic t_reset;
    #1;
    chk("R9 reset rsp_valid", 32'(rsp_valid), 32'd0);
    chk("R9 reset up_ready", 32'(up_ready), 32'd1);
    chk("R4 reset no secondary select", 32'(sec_sel), 32'd0);
  endtask

  task automatic t_bridge_defaults;
    access(24'h00_20_00, 1'b0, 2'b10, 0); chk("R8 identity dword", cap_rd, 32'h1234_ABCD);
    access(24'h00_20_04, 1'b0, 2'b10, 0); chk("R8 command/status", cap_rd, 32'h00A0_0006);
    access(24'h00_20_08, 1'b0, 2'b10, 0); chk("R8 class code", cap_rd, 32'h0604_0000);
    access(24'h00_20_0C, 1'b0, 2'b10, 0); chk("R8 latency/header", cap_rd, 32'h0081_1000);
    access(24'h00_20_1C, 1'b0, 2'b10, 0); chk("R8 secondary status", cap_rd, 32'h00A0_0000);
    access(24'h00_20_18, 1'b0, 2'b10, 0); chk("R4 secondary number resets 0", cap_rd, 32'h0);
  endtask

  task automatic t_primary;
    access(24'h00_00_40, 1'b0, 2'b10, 0);
    chk("R2 slot0 select", 32'(cap_psel), 32'h1);
    chk("R1 offset forwarded", 32'(cap_off), 32'h40);
    chk("R2 slot0 dword data", cap_rd, 32'h5A5A_0000);
    access(24'h00_01_3C, 1'b0, 2'b00, 0);
    chk("R2 slot1 select", 32'(cap_psel), 32'h2);
    chk("R10 byte read masked", cap_rd, 32'h0000_0011);
    access(24'h00_01_3C, 1'b0, 2'b01, 0);
    chk("R10 word read masked", cap_rd, 32'h0000_0011);
    access(24'h00_03_10, 1'b1, 2'b10, 32'hDEAD_BEEF);
    chk("R2 slot3 write select", 32'(cap_psel), 32'h8);
    chk("R1 write data forwarded", cap_wdata, 32'hDEAD_BEEF);
    chk("R1 write flag forwarded", 32'(cap_write), 32'd1);
    chk("R9 write response data", cap_rd, 32'h0);
    // devfn 0x08 is device 1 function 0 (bits 15:11 = 1)
    access(24'h00_08_00, 1'b0, 2'b10, 0);
    chk("R1 device field decode miss", cap_rd, 32'hFFFF_FFFF);
  endtask

  task automatic t_miss;
    access(24'h00_02_00, 1'b0, 2'b00, 0); chk("R5 byte miss", cap_rd, 32'h0000_00FF);
    chk("R5 absent slot no select", 32'(cap_psel), 32'h0);
    access(24'h00_02_00, 1'b0, 2'b01, 0); chk("R5 word miss", cap_rd, 32'h0000_FFFF);
    access(24'h00_02_00, 1'b0, 2'b10, 0); chk("R5 dword miss", cap_rd, 32'hFFFF_FFFF);
    access(24'h00_02_00, 1'b0, 2'b11, 0); chk("R5 len 11 miss", cap_rd, 32'hFFFF_FFFF);
    access(24'h05_01_00, 1'b0, 2'b10, 0);
    chk("R4 unknown bus miss", cap_rd, 32'hFFFF_FFFF);
    chk("R4 no secondary select at zero", 32'(cap_ssel), 32'h0);
    access(24'h07_00_19, 1'b1, 2'b00, 32'h33);
    chk("R6 write miss no primary select", 32'(cap_psel), 32'h0);
    chk("R6 write miss no secondary select", 32'(cap_ssel), 32'h0);
    access(24'h00_28_19, 1'b1, 2'b00, 32'h44);
    access(24'h00_20_18, 1'b0, 2'b10, 0);
    chk("R6 write miss left bridge alone", cap_rd, 32'h0);
  endtask

  task automatic t_secondary;
    access(24'h00_20_19, 1'b1, 2'b00, 32'h0000_0005);
    access(24'h00_20_18, 1'b0, 2'b10, 0);
    chk("R7 byte write at 0x19", cap_rd, 32'h0000_0500);
    access(24'h05_01_20, 1'b0, 2'b10, 0);
    chk("R3 secondary slot1 select", 32'(cap_ssel), 32'h2);
    chk("R3 secondary slot1 data", cap_rd, 32'hA5A5_0011);
    access(24'h05_03_20, 1'b0, 2'b01, 0);
    chk("R5 absent secondary word", cap_rd, 32'h0000_FFFF);
    access(24'h00_01_00, 1'b0, 2'b10, 0);
    chk("R4 bus 0 still primary", cap_rd, 32'h5A5A_0011);
    chk("R4 bus 0 no secondary select", 32'(cap_ssel), 32'h0);
    access(24'h00_20_18, 1'b1, 2'b01, 32'h0000_0907);
    access(24'h05_01_00, 1'b0, 2'b10, 0);
    chk("R7 old bus number dropped", cap_rd, 32'hFFFF_FFFF);
    access(24'h09_02_00, 1'b0, 2'b10, 0);
    chk("R7 word write at 0x18 takes bits 15:8", cap_rd, 32'hA5A5_0022);
    access(24'h00_20_18, 1'b1, 2'b10, 32'h0000_0C00);
    access(24'h0C_00_00, 1'b0, 2'b10, 0);
    chk("R7 dword write at 0x18", cap_rd, 32'hA5A5_0000);
    access(24'h00_20_19, 1'b1, 2'b00, 32'h0000_0000);
    access(24'h00_00_00, 1'b0, 2'b10, 0);
    chk("R4 zero number keeps bus 0 primary", 32'(cap_ssel), 32'h0);
  endtask

  task automatic t_bridge_writes;
    access(24'h00_20_08, 1'b1, 2'b10, 32'hFFFF_FFFF);
    access(24'h00_20_08, 1'b0, 2'b10, 0);
    chk("R11 class read-only", cap_rd, 32'h0604_0000);
    access(24'h00_20_00, 1'b1, 2'b10, 32'h0);
    access(24'h00_20_00, 1'b0, 2'b10, 0);
    chk("R11 identity read-only", cap_rd, 32'h1234_ABCD);
    access(24'h00_20_04, 1'b1, 2'b10, 32'hFFFF_1234);
    access(24'h00_20_04, 1'b0, 2'b10, 0);
    chk("R11 command writable status fixed", cap_rd, 32'h00A0_1234);
    access(24'h00_20_0D, 1'b1, 2'b00, 32'h40);
    access(24'h00_20_0C, 1'b0, 2'b10, 0);
    chk("R11 latency writable", cap_rd, 32'h0081_4000);
    access(24'h00_20_0E, 1'b0, 2'b10, 0);
    chk("R10 unaligned bridge read", cap_rd, 32'h0000_0081);
    access(24'h00_20_06, 1'b0, 2'b01, 0);
    chk("R10 word bridge read at 0x06", cap_rd, 32'h0000_00A0);
    access(24'h00_20_FE, 1'b0, 2'b10, 0);
    chk("R10 bytes past 0xFF read zero", cap_rd, 32'h0);
  endtask

  initial begin
    #2000000;
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #12 t_reset();
    @(negedge clk);
    rst_n = 1'b1;
    t_bridge_defaults();
    t_primary();
    t_miss();
    t_secondary();
    t_bridge_writes();
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule